// File: doc/BRIEF.md
# Halfword-Write / Word-Read Memory Pattern Tester

This block is a hardware self-test engine for an external memory region, typically an SDRAM behind a controller. After a start pulse it fills the region with an arithmetic pattern using only 16-bit writes. It then reads the same region back as whole 32-bit words and compares every word with the value that the two halfword writes should have packed into it. A run therefore exercises the byte-lane enables and the halfword-to-word packing of the memory path, as well as the data cells.

The pattern is built from two counters. An outer index `i` runs from 0 to `outer_cnt-1`. An inner index `j` runs from 0 to `INNER_N-1`, which is 256 by default. For each pair `(i, j)` two consecutive halfwords are written: `(i+j)` first and then `(i+j)+1`, both taken modulo 2^16. In the read phase each pair `(i, j)` corresponds to one word. The run stops at the first word that differs from the expected value.

Memory is reached through a plain request/acknowledge port. The request and its address, write enable, byte enables and write data are held until an acknowledge arrives. On a read, the acknowledge cycle also carries the read data. The memory controller, refresh and device timing are outside this block.

Top module: `pattest_top`

## Requirements
- R1: After reset, `busy`, `done`, `pass`, `fail` and `mem_req` are all 0.
- R2: On a start accepted with `outer_cnt` N > 0, the block issues exactly N*INNER_N*2 writes. The writes go to consecutive halfword addresses, stepping by 2 bytes, beginning at `base_addr` with its two low bits forced to 0.
- R3: For each (i, j), in the order i outer and j inner, the block writes value (i+j) mod 2^16 and then (i+j+1) mod 2^16.
- R4: A write to an address with bit 1 = 0 uses `mem_be` = 4'b0011 and carries the value in `mem_wdata[15:0]`, with bits 31:16 at zero. A write to an address with bit 1 = 1 uses `mem_be` = 4'b1100 and carries the value in `mem_wdata[31:16]`, with bits 15:0 at zero.
- R5: After the last write, reads start again at the aligned base and step by 4 bytes, one word per (i, j). Every read has `mem_be` = 4'b1111 and `mem_we` = 0.
- R6: The word expected for (i, j) is {(i+j+1) mod 2^16, (i+j) mod 2^16}, with the upper value in bits 31:16. If all N*INNER_N words match, the run ends with `pass` = 1 and `fail` = 0.
- R7: The first read word that differs from its expected value ends the run with `fail` = 1 and `pass` = 0. No further memory access is issued after that read.
- R8: While `mem_req` is 1 and `mem_ack` is 0, the address, write enable, byte enables and write data stay unchanged. The block moves to the next access only after an acknowledge.
- R9: The end of a run is marked by `done` = 1 for exactly one cycle, with `busy` = 0 in that cycle. `pass` and `fail` keep their values until the next accepted start, which clears both in the cycle after it.
- R10: A start seen while `busy` = 1 has no effect. The running pass keeps its base, its count, its access sequence and its result.
- R11: A start with `outer_cnt` = 0 issues no memory access. It gives `done` = 1 and `pass` = 1 in the cycle after the start.
- R12: A start given in the same cycle as the `done` pulse is accepted. `busy` is 1 in the following cycle, and that run proceeds normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a run when the block is idle |
| base_addr | input | ADDR_W | Byte address of the region; bits 1:0 are ignored |
| outer_cnt | input | OUTER_W | Number of outer iterations |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Last run matched everywhere |
| fail | output | 1 | Last run stopped on a mismatch |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes in this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` on reads |

## Verification
Two events can land in the same cycle. The first is the end of one run and the start of the next: the bench watches for the `done` pulse and drives `start` in that very cycle. It then judges the outcome from `busy` in the next cycle and from a complete, correct access sequence for the new run. The second is the end of the final read of a region coinciding with a mismatch. The memory model corrupts the last word of a region, and the bench expects `fail` rather than `pass` with no further access. A scoreboard fed with the expected access list compares every acknowledged access, so any extra, missing or reordered access is reported.

// File: rtl/pattest_pkg.sv
package pattest_pkg;

    localparam int HALF_W = 16;
    localparam int WORD_W = 32;
    localparam int BE_W   = WORD_W / 8;

    localparam logic [BE_W-1:0] BE_LO   = 4'b0011;
    localparam logic [BE_W-1:0] BE_HI   = 4'b1100;
    localparam logic [BE_W-1:0] BE_FULL = 4'b1111;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WRITE = 2'd1,
        PH_READ  = 2'd2
    } phase_e;

    typedef struct packed {
        logic              we;
        logic [BE_W-1:0]   be;
        logic [WORD_W-1:0] wdata;
    } lane_cmd_t;

    // Halfword value for outer index oi, inner index ii; second selects the +1 half.
    function automatic logic [HALF_W-1:0] half_value(input logic [31:0] oi,
                                                     input logic [31:0] ii,
                                                     input logic        second);
        logic [31:0] sum;
        sum = oi + ii + {31'd0, second};
        return sum[HALF_W-1:0];
    endfunction

    // Word expected after both halfwords of one (outer, inner) step are packed.
    function automatic logic [WORD_W-1:0] word_value(input logic [31:0] oi,
                                                     input logic [31:0] ii);
        return {half_value(oi, ii, 1'b1), half_value(oi, ii, 1'b0)};
    endfunction

endpackage

// File: rtl/pattest_ctrl.sv
module pattest_ctrl
    import pattest_pkg::*;
#(
    parameter int OUTER_W = 16,
    parameter int INNER_N = 256,
    localparam int INNER_W = (INNER_N > 1) ? $clog2(INNER_N) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [OUTER_W-1:0] outer_cnt,
    input  logic               ack,
    input  logic               mismatch,
    output phase_e             phase,
    output logic [OUTER_W-1:0] idx_o,
    output logic [INNER_W-1:0] idx_i,
    output logic               hsel,
    output logic               accept,
    output logic               restart,
    output logic               done,
    output logic               pass,
    output logic               fail
);

    localparam logic [INNER_W-1:0] INNER_LAST = INNER_W'(INNER_N - 1);

    logic [OUTER_W-1:0] outer_q;
    logic               last_inner;
    logic               last_outer;

    assign last_inner = (idx_i == INNER_LAST);
    assign last_outer = (idx_o == outer_q - OUTER_W'(1));
    assign accept     = (phase == PH_IDLE) && start;
    assign restart    = (phase == PH_WRITE) && ack && hsel && last_inner && last_outer;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            idx_o   <= '0;
            idx_i   <= '0;
            hsel    <= 1'b0;
            outer_q <= '0;
            done    <= 1'b0;
            pass    <= 1'b0;
            fail    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        outer_q <= outer_cnt;
                        idx_o   <= '0;
                        idx_i   <= '0;
                        hsel    <= 1'b0;
                        fail    <= 1'b0;
                        if (outer_cnt == '0) begin
                            done <= 1'b1;
                            pass <= 1'b1;
                        end else begin
                            pass  <= 1'b0;
                            phase <= PH_WRITE;
                        end
                    end
                end
                PH_WRITE: begin
                    if (ack) begin
                        if (!hsel) begin
                            hsel <= 1'b1;
                        end else begin
                            hsel <= 1'b0;
                            if (last_inner) begin
                                idx_i <= '0;
                                if (last_outer) begin
                                    idx_o <= '0;
                                    phase <= PH_READ;
                                end else begin
                                    idx_o <= idx_o + OUTER_W'(1);
                                end
                            end else begin
                                idx_i <= idx_i + INNER_W'(1);
                            end
                        end
                    end
                end
                PH_READ: begin
                    if (ack) begin
                        if (mismatch) begin
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                            fail  <= 1'b1;
                        end else if (last_inner) begin
                            idx_i <= '0;
                            if (last_outer) begin
                                phase <= PH_IDLE;
                                done  <= 1'b1;
                                pass  <= 1'b1;
                            end else begin
                                idx_o <= idx_o + OUTER_W'(1);
                            end
                        end else begin
                            idx_i <= idx_i + INNER_W'(1);
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pattest_agen.sv
module pattest_agen
    import pattest_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] base_in,
    input  logic              restart,
    input  logic              ack,
    input  phase_e            phase,
    input  logic [HALF_W-1:0] hw_value,
    output logic [ADDR_W-1:0] addr,
    output lane_cmd_t         cmd
);

    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);
    localparam logic [ADDR_W-1:0] STEP_HALF  = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] STEP_WORD  = ADDR_W'(4);

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            addr_q <= '0;
        end else if (accept) begin
            base_q <= base_in & ALIGN_MASK;
            addr_q <= base_in & ALIGN_MASK;
        end else if (restart) begin
            addr_q <= base_q;
        end else if (ack && phase != PH_IDLE) begin
            addr_q <= addr_q + ((phase == PH_READ) ? STEP_WORD : STEP_HALF);
        end
    end

    assign addr = addr_q;

    always_comb begin
        cmd = '0;
        case (phase)
            PH_WRITE: begin
                cmd.we = 1'b1;
                if (addr_q[1]) begin
                    cmd.be    = BE_HI;
                    cmd.wdata = {hw_value, {HALF_W{1'b0}}};
                end else begin
                    cmd.be    = BE_LO;
                    cmd.wdata = {{HALF_W{1'b0}}, hw_value};
                end
            end
            PH_READ: begin
                cmd.we = 1'b0;
                cmd.be = BE_FULL;
            end
            default: cmd = '0;
        endcase
    end

endmodule

// File: rtl/pattest_cmp.sv
module pattest_cmp
    import pattest_pkg::*;
#(
    parameter int OUTER_W = 16,
    parameter int INNER_W = 8
) (
    input  phase_e             phase,
    input  logic               ack,
    input  logic [WORD_W-1:0]  rdata,
    input  logic [OUTER_W-1:0] idx_o,
    input  logic [INNER_W-1:0] idx_i,
    output logic               mismatch
);

    logic [WORD_W-1:0] expect_w;

    assign expect_w = word_value(32'(idx_o), 32'(idx_i));
    assign mismatch = (phase == PH_READ) && ack && (rdata != expect_w);

endmodule

// File: rtl/pattest_top.sv
module pattest_top
    import pattest_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int OUTER_W = 16,
    parameter int INNER_N = 256
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [ADDR_W-1:0]  base_addr,
    input  logic [OUTER_W-1:0] outer_cnt,
    output logic               busy,
    output logic               done,
    output logic               pass,
    output logic               fail,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [3:0]         mem_be,
    output logic [31:0]        mem_wdata,
    input  logic               mem_ack,
    input  logic [31:0]        mem_rdata
);

    localparam int INNER_W = (INNER_N > 1) ? $clog2(INNER_N) : 1;

    phase_e             phase;
    logic [OUTER_W-1:0] idx_o;
    logic [INNER_W-1:0] idx_i;
    logic               hsel;
    logic               accept;
    logic               restart;
    logic               mismatch;
    logic [HALF_W-1:0]  hw_value;
    lane_cmd_t          cmd;

    assign hw_value = half_value(32'(idx_o), 32'(idx_i), hsel);

    pattest_ctrl #(
        .OUTER_W (OUTER_W),
        .INNER_N (INNER_N)
    ) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .outer_cnt (outer_cnt),
        .ack       (mem_ack),
        .mismatch  (mismatch),
        .phase     (phase),
        .idx_o     (idx_o),
        .idx_i     (idx_i),
        .hsel      (hsel),
        .accept    (accept),
        .restart   (restart),
        .done      (done),
        .pass      (pass),
        .fail      (fail)
    );

    pattest_agen #(
        .ADDR_W (ADDR_W)
    ) agen_i (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .base_in  (base_addr),
        .restart  (restart),
        .ack      (mem_ack),
        .phase    (phase),
        .hw_value (hw_value),
        .addr     (mem_addr),
        .cmd      (cmd)
    );

    pattest_cmp #(
        .OUTER_W (OUTER_W),
        .INNER_W (INNER_W)
    ) cmp_i (
        .phase    (phase),
        .ack      (mem_ack),
        .rdata    (mem_rdata),
        .idx_o    (idx_o),
        .idx_i    (idx_i),
        .mismatch (mismatch)
    );

    assign busy      = (phase != PH_IDLE);
    assign mem_req   = (phase != PH_IDLE);
    assign mem_we    = cmd.we;
    assign mem_be    = cmd.be;
    assign mem_wdata = cmd.wdata;

endmodule

// File: rtl/pattest_chk.sv
module pattest_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              pass,
    input logic              fail,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [3:0]        mem_be,
    input logic [31:0]       mem_wdata,
    input logic              mem_ack
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);

    assert_half_step_R2: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we && mem_ack |=> !mem_we || (mem_addr == $past(mem_addr) + ADDR_W'(2)));

    assert_lane_R4: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> (mem_be == (mem_addr[1] ? 4'b1100 : 4'b0011)));

    assert_read_shape_R5: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_we |-> (mem_be == 4'b1111) && (mem_addr[1:0] == 2'b00));

    assert_word_step_R5: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_we && mem_ack |=> !mem_req || (mem_addr == $past(mem_addr) + ADDR_W'(4)));

    assert_verdict_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(pass && fail));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_be) && $stable(mem_wdata));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_verdict_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !busy && !start |=> $stable(pass) && $stable(fail));

    assert_ignore_start_R10: assert property (@(posedge clk) disable iff (rst)
        busy && start && !mem_ack |=> busy);

endmodule

bind pattest_top pattest_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .pass      (pass),
    .fail      (fail),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack)
);

// File: tb/pattest_top_tb_top.sv
`timescale 1ns/1ps
module pattest_top_tb_top;

    localparam int ADDR_W  = 32;
    localparam int OUTER_W = 16;
    localparam int INNER_N = 256;

    typedef struct {
        bit          we;
        logic [31:0] addr;
        logic [3:0]  be;
        logic [31:0] data;
    } exp_t;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start = 1'b0;
    logic [ADDR_W-1:0]  base_addr = '0;
    logic [OUTER_W-1:0] outer_cnt = '0;
    logic               busy, done, pass, fail;
    logic               mem_req, mem_we;
    logic [ADDR_W-1:0]  mem_addr;
    logic [3:0]         mem_be;
    logic [31:0]        mem_wdata;
    logic               mem_ack = 1'b0;
    logic [31:0]        mem_rdata = '0;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    exp_t sb_q[$];

    logic [31:0] mem [logic [31:0]];
    bit          corrupt_en = 1'b0;
    logic [31:0] corrupt_addr = '0;
    int          lat = 0;
    int          wcnt = 0;
    logic [31:0] cur;

    always #10 clk = ~clk;

    pattest_top #(
        .ADDR_W  (ADDR_W),
        .OUTER_W (OUTER_W),
        .INNER_N (INNER_N)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .base_addr (base_addr),
        .outer_cnt (outer_cnt),
        .busy      (busy),
        .done      (done),
        .pass      (pass),
        .fail      (fail),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_be    (mem_be),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata)
    );

    // Memory model with a varying wait of 0..2 cycles before each acknowledge.
    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            wcnt    <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (wcnt < lat) begin
                wcnt <= wcnt + 1;
            end else begin
                wcnt    <= 0;
                lat     <= (lat + 1) % 3;
                mem_ack <= 1'b1;
                cur = mem.exists(mem_addr >> 2) ? mem[mem_addr >> 2] : 32'h0;
                if (mem_we) begin
                    for (int b = 0; b < 4; b++)
                        if (mem_be[b]) cur[b*8 +: 8] = mem_wdata[b*8 +: 8];
                    mem[mem_addr >> 2] = cur;
                end else begin
                    mem_rdata <= (corrupt_en && mem_addr == corrupt_addr) ? (cur ^ 32'h0000_0100) : cur;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: compares each acknowledged access with the scoreboard head.
    always @(negedge clk) begin
        if (!rst && mem_req && mem_ack) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R7", "access with empty scoreboard", mem_addr, 32'h0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(mem_we == e.we, "R5", "write enable", {31'd0, mem_we}, {31'd0, e.we});
                check(mem_addr == e.addr, "R2/R5/R8", "address", mem_addr, e.addr);
                check(mem_be == e.be, "R4", "byte enables", {28'd0, mem_be}, {28'd0, e.be});
                if (e.we)
                    check(mem_wdata == e.data, "R3/R4", "write data", mem_wdata, e.data);
            end
        end
    end

    // Driver: pushes the access list a run must produce; stop_at < 0 means all reads.
    task automatic push_run(input logic [31:0] base, input int outer, input int stop_at);
        logic [31:0] a;
        logic [15:0] v;
        int nrd;
        a = base & ~32'h3;
        for (int i = 0; i < outer; i++)
            for (int j = 0; j < INNER_N; j++)
                for (int h = 0; h < 2; h++) begin
                    exp_t e;
                    v = 16'((i + j + h) & 16'hFFFF);
                    e.we = 1'b1;
                    e.addr = a + 32'(2 * ((i * INNER_N + j) * 2 + h));
                    e.be = (h == 0) ? 4'b0011 : 4'b1100;
                    e.data = (h == 0) ? {16'h0, v} : {v, 16'h0};
                    sb_q.push_back(e);
                end
        nrd = (stop_at < 0) ? outer * INNER_N : stop_at + 1;
        for (int k = 0; k < nrd; k++) begin
            exp_t e;
            e.we = 1'b0;
            e.addr = a + 32'(4 * k);
            e.be = 4'b1111;
            e.data = 32'h0;
            sb_q.push_back(e);
        end
    endtask

    task automatic pulse_start(input logic [31:0] base, input int outer);
        @(negedge clk);
        start = 1'b1;
        base_addr = base;
        outer_cnt = OUTER_W'(outer);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n;
        n = 0;
        while (!done && n < 30000) begin
            @(negedge clk);
            n++;
        end
        check(done == 1'b1, req, "done reached", {31'd0, done}, 32'd1);
    endtask

    // Watchdog
    initial begin
        forever begin
            @(negedge clk);
            cycles++;
            if (cycles > 150000) begin
                check(1'b0, "R1", "watchdog expired", 32'(cycles), 32'd150000);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check({busy, done, pass, fail, mem_req} == 5'b0, "R1", "idle outputs",
              {27'd0, busy, done, pass, fail, mem_req}, 32'd0);

        // R2 R3 R4 R5 R6: single outer iteration
        push_run(32'h0000_1000, 1, -1);
        pulse_start(32'h0000_1000, 1);
        check(busy == 1'b1, "R2", "busy after start", {31'd0, busy}, 32'd1);
        wait_done("R6");
        check(pass == 1'b1 && fail == 1'b0, "R6", "verdict outer=1", {30'd0, pass, fail}, 32'd2);
        check(busy == 1'b0, "R9", "busy low with done", {31'd0, busy}, 32'd0);
        check(sb_q.size() == 0, "R2", "all accesses seen", 32'(sb_q.size()), 32'd0);

        // R9 verdict holds, done lasts one cycle
        @(negedge clk);
        check(done == 1'b0, "R9", "done single cycle", {31'd0, done}, 32'd0);
        repeat (3) @(negedge clk);
        check(pass == 1'b1, "R9", "pass held", {31'd0, pass}, 32'd1);

        // R2: unaligned base, three outer iterations; start clears verdict
        push_run(32'h0002_0003, 3, -1);
        pulse_start(32'h0002_0003, 3);
        check(pass == 1'b0 && fail == 1'b0, "R9", "verdict cleared by start", {30'd0, pass, fail}, 32'd0);
        wait_done("R6");
        check(pass == 1'b1 && fail == 1'b0, "R6", "verdict outer=3", {30'd0, pass, fail}, 32'd2);
        check(sb_q.size() == 0, "R5", "all reads seen", 32'(sb_q.size()), 32'd0);

        // R7: mismatch in the middle of the second outer pass
        corrupt_en = 1'b1;
        corrupt_addr = 32'h0000_4000 + 32'(4 * 300);
        push_run(32'h0000_4000, 2, 300);
        pulse_start(32'h0000_4000, 2);
        wait_done("R7");
        check(fail == 1'b1 && pass == 1'b0, "R7", "verdict on mismatch", {30'd0, pass, fail}, 32'd1);
        repeat (4) @(negedge clk);
        check(sb_q.size() == 0 && mem_req == 1'b0, "R7", "no access after mismatch", 32'(sb_q.size()), 32'd0);

        // R7: mismatch on the very last word
        corrupt_addr = 32'h0000_6000 + 32'(4 * (INNER_N - 1));
        push_run(32'h0000_6000, 1, INNER_N - 1);
        pulse_start(32'h0000_6000, 1);
        wait_done("R7");
        check(fail == 1'b1 && pass == 1'b0, "R7", "last word mismatch", {30'd0, pass, fail}, 32'd1);
        corrupt_en = 1'b0;

        // R11: zero outer count
        pulse_start(32'h0000_7000, 0);
        check(done == 1'b1 && pass == 1'b1 && fail == 1'b0, "R11", "zero count result",
              {29'd0, done, pass, fail}, 32'd6);
        check(busy == 1'b0 && mem_req == 1'b0, "R11", "no activity", {30'd0, busy, mem_req}, 32'd0);

        // R10: start while busy with other base and count
        push_run(32'h0000_8000, 1, -1);
        pulse_start(32'h0000_8000, 1);
        repeat (40) @(negedge clk);
        start = 1'b1;
        base_addr = 32'h0000_C000;
        outer_cnt = OUTER_W'(5);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R10", "still busy after ignored start", {31'd0, busy}, 32'd1);
        wait_done("R10");
        check(pass == 1'b1 && sb_q.size() == 0, "R10", "original run intact",
              {31'd0, pass}, 32'd1);

        // R12: start in the done cycle
        push_run(32'h0000_9000, 1, -1);
        start = 1'b1;
        base_addr = 32'h0000_9000;
        outer_cnt = OUTER_W'(1);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R12", "start in done cycle accepted", {31'd0, busy}, 32'd1);
        wait_done("R12");
        check(pass == 1'b1 && sb_q.size() == 0, "R12", "back-to-back run result",
              {31'd0, pass}, 32'd1);

        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule